// File: doc/BRIEF.md
# Power Transition Time Stamp Capture

This block keeps a record of when the chip's supply source last changed. It watches a supply-status input that is high while the device runs from its backup battery. When that input changes, the block copies the live calendar fields (seconds, minutes, hours, date, month) into one of two stamp banks. A switch from main supply onto battery goes into the "onto-battery" bank. A switch from battery back onto main supply goes into the "onto-main" bank.

The two banks follow opposite policies. The onto-battery bank keeps the first switchover it sees and ignores later ones until software clears it. The onto-main bank is rewritten on every return to main supply, so it always holds the most recent one. A cleared bank reads all zeros. A real calendar date is never zero, so any non-zero content shows that a switchover has been stamped since the last clear or reset. Software reads the banks through a small byte-wide register port. It clears both banks by writing a one to a strobe bit that reads back as zero.

The supply-status input is asynchronous and passes through a synchronizer before edge detection. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `pwr_tstamp_top`

## Requirements
- R1: After reset, every stamp byte in both banks reads 0x00.
- R2: A low-to-high change of `on_battery` loads the current time fields into the onto-battery bank when that bank is empty. The new contents can be read from the fourth rising clock edge after the input changes.
- R3: While the onto-battery bank holds a stamp, later low-to-high changes of `on_battery` leave its contents unchanged.
- R4: Every high-to-low change of `on_battery` overwrites the onto-main bank with the current time fields, so the bank holds the latest such event.
- R5: A write to address 10 with data bit 0 set clears both banks to all zeros and makes the onto-battery bank accept the next switchover again.
- R6: Address 10 always reads 0x00. A write to address 10 with bit 0 clear has no effect. Writes to any stamp address (0 to 9) are ignored.
- R7: If a supply change is detected in the same cycle as a clear write, the cleared bank that the change targets holds the new stamp afterwards, so the event is not lost.
- R8: The read map has the onto-battery bank at addresses 0 to 4 and the onto-main bank at addresses 5 to 9, each ordered seconds, minutes, hours, date, month. Addresses 11 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| on_battery | input | 1 | Asynchronous supply status, high while running on battery |
| cur_sec | input | 8 | Current seconds field |
| cur_min | input | 8 | Current minutes field |
| cur_hour | input | 8 | Current hours field |
| cur_date | input | 8 | Current date field |
| cur_month | input | 8 | Current month field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |

## Verification
A stuck or wrongly set first-event flag in the onto-battery bank shows as a missed first stamp or an overwritten one. The bad value can be read on `rd_data` one read after the fourth clock edge that follows the next rising `on_battery`. A synchronizer or edge detector that fires twice, or not at all, shows within the same window as a stale onto-main stamp, or as an onto-battery stamp that a clear could not re-arm. A faulty clear-and-capture priority only shows when a clear write lands on the detection cycle, so that case is driven with cycle-exact alignment.

// File: rtl/pwr_tstamp_pkg.sv
package pwr_tstamp_pkg;
  // Number of calendar fields held by each stamp bank (sec, min, hour, date, month)
  localparam int NUM_FIELDS = 5;

  // Capture policy of a stamp bank
  typedef enum logic {
    CAP_FIRST = 1'b0,
    CAP_LAST  = 1'b1
  } cap_policy_e;
endpackage

// File: rtl/pts_rst_sync.sv
module pts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pts_edge_det.sv
module pts_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;
endmodule

// File: rtl/pts_stamp_bank.sv
module pts_stamp_bank
  import pwr_tstamp_pkg::*;
#(
  parameter int          FW     = 8,
  parameter cap_policy_e POLICY = CAP_LAST
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           event_i,
  input  logic                           clear_i,
  input  logic [NUM_FIELDS-1:0][FW-1:0]  time_i,
  output logic [NUM_FIELDS-1:0][FW-1:0]  bank_o,
  output logic                           full_o
);
  logic [NUM_FIELDS-1:0][FW-1:0] bank_q;
  logic [NUM_FIELDS-1:0][FW-1:0] bank_d;
  logic                          full_q;
  logic                          full_d;
  logic                          armed;
  logic                          capture;
  logic                          bank_en;

  generate
    if (POLICY == CAP_FIRST) begin : g_first
      // Only an empty bank (or one being cleared this cycle) accepts a stamp
      assign armed = ~full_q | clear_i;
    end else begin : g_last
      assign armed = 1'b1;
    end
  endgenerate

  assign capture = event_i & armed;
  assign bank_en = capture | clear_i;

  always_comb begin
    bank_d = bank_q;
    full_d = full_q;
    if (clear_i) begin
      bank_d = '0;
      full_d = 1'b0;
    end
    if (capture) begin
      bank_d = time_i;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      full_q <= 1'b0;
    end else if (bank_en) begin
      bank_q <= bank_d;
      full_q <= full_d;
    end
  end

  assign bank_o = bank_q;
  assign full_o = full_q;
endmodule

// File: rtl/pwr_tstamp_top.sv
module pwr_tstamp_top
  import pwr_tstamp_pkg::*;
#(
  parameter int FW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          on_battery,
  input  logic [FW-1:0] cur_sec,
  input  logic [FW-1:0] cur_min,
  input  logic [FW-1:0] cur_hour,
  input  logic [FW-1:0] cur_date,
  input  logic [FW-1:0] cur_month,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [FW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [FW-1:0] rd_data
);
  localparam int BATT_BASE = 0;
  localparam int MAIN_BASE = BATT_BASE + NUM_FIELDS;
  localparam int CTRL_ADDR = MAIN_BASE + NUM_FIELDS;

  logic                          rst_n;
  logic                          rise;
  logic                          fall;
  logic                          clr_pulse;
  logic [NUM_FIELDS-1:0][FW-1:0] cur_time;
  logic [NUM_FIELDS-1:0][FW-1:0] bank_batt;
  logic [NUM_FIELDS-1:0][FW-1:0] bank_main;
  logic                          full_batt;
  logic                          full_main;

  pts_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pts_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (on_battery),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  assign cur_time = {cur_month, cur_date, cur_hour, cur_min, cur_sec};

  // Clear strobe: no storage, so the control register reads back as zero
  assign clr_pulse = wr_en && (wr_addr == AW'(CTRL_ADDR)) && wr_data[0];

  pts_stamp_bank #(.FW(FW), .POLICY(CAP_FIRST)) u_batt (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (rise),
    .clear_i (clr_pulse),
    .time_i  (cur_time),
    .bank_o  (bank_batt),
    .full_o  (full_batt)
  );

  pts_stamp_bank #(.FW(FW), .POLICY(CAP_LAST)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (fall),
    .clear_i (clr_pulse),
    .time_i  (cur_time),
    .bank_o  (bank_main),
    .full_o  (full_main)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_addr == AW'(BATT_BASE + i)) rd_data = bank_batt[i];
      if (rd_addr == AW'(MAIN_BASE + i)) rd_data = bank_main[i];
    end
  end
endmodule

// File: rtl/pts_checker.sv
module pts_checker
  import pwr_tstamp_pkg::*;
#(
  parameter int FW        = 8,
  parameter int AW        = 4,
  parameter int CTRL_ADDR = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rise,
  input logic                          fall,
  input logic                          clr_pulse,
  input logic                          full_batt,
  input logic [NUM_FIELDS-1:0][FW-1:0] cur_time,
  input logic [NUM_FIELDS-1:0][FW-1:0] bank_batt,
  input logic [NUM_FIELDS-1:0][FW-1:0] bank_main,
  input logic [AW-1:0]                 rd_addr,
  input logic [FW-1:0]                 rd_data
);
  a_r2_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !full_batt) |=> (bank_batt == $past(cur_time)));

  a_r3_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    (full_batt && !clr_pulse) |=> $stable(bank_batt));

  a_r4_last_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (bank_main == $past(cur_time)));

  a_r5_clear_batt: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !rise) |=> (bank_batt == '0 && !full_batt));

  a_r5_clear_main: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !fall) |=> (bank_main == '0));

  a_r6_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(CTRL_ADDR)) |-> (rd_data == '0));

  a_r7_clear_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && rise) |=> (bank_batt == $past(cur_time) && full_batt));

  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

bind pwr_tstamp_top pts_checker #(.FW(FW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise      (rise),
  .fall      (fall),
  .clr_pulse (clr_pulse),
  .full_batt (full_batt),
  .cur_time  (cur_time),
  .bank_batt (bank_batt),
  .bank_main (bank_main),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data)
);

// File: tb/sim_pwr_tstamp_top.sv
`timescale 1ns/1ps
module sim_pwr_tstamp_top;
  logic       clk;
  logic       arst_n;
  logic       on_battery;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_date, cur_month;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  pwr_tstamp_top u0 (
    .clk(clk), .arst_n(arst_n), .on_battery(on_battery),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dt, mo);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt; cur_month = mo;
  endtask

  task automatic supply(input logic v);
    @(negedge clk);
    on_battery = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic check_bank(input string req, input logic [3:0] base,
                            input logic [7:0] s, m, h, dt, mo);
    logic [7:0] d;
    logic [7:0] exp [5];
    exp[0] = s; exp[1] = m; exp[2] = h; exp[3] = dt; exp[4] = mo;
    for (int i = 0; i < 5; i++) begin
      rd(base + 4'(i), d);
      check(req, d, exp[i]);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check("R1 reset stamp byte", d, 8'h00);
    end
    rd(4'd10, d);
    check("R6 control reads zero", d, 8'h00);
    for (int a = 11; a < 16; a++) begin
      rd(4'(a), d);
      check("R8 unmapped address", d, 8'h00);
    end
  endtask

  task automatic t_first_capture;
    set_time(8'h12, 8'h34, 8'h05, 8'h17, 8'h03);
    supply(1'b1);
    check_bank("R2 onto-battery stamp", 4'd0, 8'h12, 8'h34, 8'h05, 8'h17, 8'h03);
    check_bank("R8 onto-main untouched", 4'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_back_main;
    set_time(8'h45, 8'h10, 8'h22, 8'h18, 8'h03);
    supply(1'b0);
    check_bank("R4 onto-main stamp", 4'd5, 8'h45, 8'h10, 8'h22, 8'h18, 8'h03);
  endtask

  task automatic t_repeat_events;
    set_time(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    supply(1'b1);
    check_bank("R3 first stamp kept", 4'd0, 8'h12, 8'h34, 8'h05, 8'h17, 8'h03);
    set_time(8'h59, 8'h58, 8'h23, 8'h31, 8'h12);
    supply(1'b0);
    check_bank("R4 latest onto-main", 4'd5, 8'h59, 8'h58, 8'h23, 8'h31, 8'h12);
  endtask

  task automatic t_ignored_writes;
    logic [7:0] d;
    wr(4'd10, 8'hFE);
    wr(4'd0, 8'hFF);
    wr(4'd7, 8'hAA);
    check_bank("R6 onto-battery unchanged", 4'd0, 8'h12, 8'h34, 8'h05, 8'h17, 8'h03);
    check_bank("R6 onto-main unchanged", 4'd5, 8'h59, 8'h58, 8'h23, 8'h31, 8'h12);
    rd(4'd10, d);
    check("R6 control reads zero", d, 8'h00);
  endtask

  task automatic t_clear;
    wr(4'd10, 8'h01);
    check_bank("R5 onto-battery cleared", 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check_bank("R5 onto-main cleared", 4'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    set_time(8'h30, 8'h30, 8'h11, 8'h01, 8'h01);
    supply(1'b1);
    check_bank("R5 re-armed capture", 4'd0, 8'h30, 8'h30, 8'h11, 8'h01, 8'h01);
  endtask

  task automatic t_coincident;
    set_time(8'h07, 8'h08, 8'h09, 8'h10, 8'h11);
    supply(1'b0);
    set_time(8'h21, 8'h22, 8'h13, 8'h24, 8'h06);
    @(negedge clk);
    on_battery = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd10; wr_data = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check_bank("R7 event kept over clear", 4'd0, 8'h21, 8'h22, 8'h13, 8'h24, 8'h06);
    check_bank("R7 other bank cleared", 4'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; on_battery = 1'b0;
    cur_sec = '0; cur_min = '0; cur_hour = '0; cur_date = 8'h01; cur_month = 8'h01;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_first_capture();
    t_back_main();
    t_repeat_events();
    t_ignored_writes();
    t_clear();
    t_coincident();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule